// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 64 pins, grouped into banks of 32. Software reaches it through a single-cycle register port: an address, a write strobe, a 32-bit write word and a combinational read word. Each pin has a direction bit, a drive value, an interrupt enable, and an interrupt detection mode. The mode is made of a type bit (level or edge) and a polarity bit (active high or active low).

Pin inputs pass through a two-flop synchroniser before any detection. Qualifying events set a sticky per-pin status bit, which software clears by writing one to it. A single interrupt line goes to the parent interrupt controller. It is high while any pin has both its status bit and its enable bit set. The register port is plain control with no flow control, so it has no back-pressure: every write takes effect on the clock edge where the strobe is sampled.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register word reads zero, `pin_oe` is all zero (every pin an input), `pin_out` is zero and `irq_out` is low.
- R2: Each feature uses one 32-bit word per bank. Pin p is bit p%32 of the word at the feature base plus (p/32)*4. The bases are 0x00 for direction, 0x08 for drive, 0x18 for enable, 0x38 for polarity, 0x40 for type and 0x48 for status. Direction, enable, polarity and type read back what was written. Any other address reads zero.
- R3: A direction bit of 1 makes the pin an output, so `pin_oe[p]`=1. `pin_out[p]` carries the drive bit written for that pin.
- R4: Reading the drive word returns the pin levels as seen after the two-flop synchroniser, not the written drive values. A change on `pin_in` shows up in a read after the second rising clock edge.
- R5: With type bit 0 (level), the status bit sets while the synchronised pin is at its active level (polarity 0 = high, 1 = low). A clear does not take effect while that level persists.
- R6: With type bit 1 (edge), the status bit sets on a transition of the synchronised pin into its active level: polarity 0 means a rising edge and polarity 1 means a falling edge. The opposite transition, or a steady level, sets nothing.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: If a qualifying event and a write-one clear of the same status bit fall on the same clock edge, the bit stays set.
- R9: `irq_out` is high exactly when some pin has both its status bit and its enable bit set. A disabled pin still latches status but does not raise `irq_out`.
- R10: Bits for pins at or above `NUM_PINS` read zero, ignore writes and never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears every register |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr_en | input | 1 | Write strobe; the write happens at this clock edge |
| reg_wdata | input | 32 | Write data word |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Drive value toward the pads |
| pin_oe | output | NUM_PINS | Output enable per pin, 1 = output |
| irq_out | output | 1 | Aggregate interrupt to the parent controller |

## Verification
All four type/polarity combinations are swept across pins at both ends of each bank, including the last pin of a partial second bank. Each pin is driven into its active level and then back out. This separates level from edge behaviour: a level pin re-asserts after a clear, while an edge pin stays clear and ignores the return transition. Zero-writes and one-writes to status tell stickiness apart from clearing. Toggling the enable around a latched status shows that status and interrupt are separate. Two further patterns cover the remaining cases. A rising edge is timed to land on the same edge as a clear, to show the event takes priority. All-ones writes into the partial bank show that the absent pins hold nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_DRV  = 8'h08;
  localparam logic [7:0] OFS_IEN  = 8'h18;
  localparam logic [7:0] OFS_POL  = 8'h38;
  localparam logic [7:0] OFS_TYP  = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h48;

  typedef enum logic [2:0] {
    FEAT_NONE,
    FEAT_DIR,
    FEAT_DRV,
    FEAT_IEN,
    FEAT_POL,
    FEAT_TYP,
    FEAT_STAT
  } feat_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output feat_e             feat,
  output logic [BIDX_W-1:0] bank
);
  always_comb begin
    feat = FEAT_NONE;
    bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(OFS_DIR + 8'(b * 4))) begin
        feat = FEAT_DIR;  bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(OFS_DRV + 8'(b * 4))) begin
        feat = FEAT_DRV;  bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(OFS_IEN + 8'(b * 4))) begin
        feat = FEAT_IEN;  bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(OFS_POL + 8'(b * 4))) begin
        feat = FEAT_POL;  bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(OFS_TYP + 8'(b * 4))) begin
        feat = FEAT_TYP;  bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(OFS_STAT + 8'(b * 4))) begin
        feat = FEAT_STAT; bank = BIDX_W'(b);
      end
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_mode,
  input  logic active_low,
  output logic evt
);
  logic prev_q;
  logic now_act;
  logic was_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign now_act = lvl ^ active_low;
  assign was_act = prev_q ^ active_low;
  assign evt     = edge_mode ? (now_act & ~was_act) : now_act;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr_en,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_BANKS * WORD_W;
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  function automatic logic [PAD_W-1:0] pin_mask();
    logic [PAD_W-1:0] m;
    for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction
  localparam logic [PAD_W-1:0] VALID_MASK = pin_mask();

  feat_e             feat;
  logic [BIDX_W-1:0] bank;
  logic [PAD_W-1:0]  wr_word;
  logic [PAD_W-1:0]  wr_keep;
  logic [PAD_W-1:0]  dir_q, drv_q, ien_q, pol_q, typ_q, stat_q;
  logic [PAD_W-1:0]  clr_vec, evt_vec, lvl_pad;
  logic [NUM_PINS-1:0] lvl_sync;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr (reg_addr),
    .feat (feat),
    .bank (bank)
  );

  gpio_sync2 #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  assign lvl_pad = PAD_W'(lvl_sync);

  // Write word placed at the addressed bank, and a mask of the bits it covers
  assign wr_word = (PAD_W'(reg_wdata) << (WORD_W * int'(bank))) & VALID_MASK;
  assign wr_keep = ~(PAD_W'({WORD_W{1'b1}}) << (WORD_W * int'(bank)));
  assign clr_vec = (reg_wr_en && feat == FEAT_STAT) ? wr_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
      ien_q <= '0;
      pol_q <= '0;
      typ_q <= '0;
    end else if (reg_wr_en) begin
      case (feat)
        FEAT_DIR: dir_q <= (dir_q & wr_keep) | wr_word;
        FEAT_DRV: drv_q <= (drv_q & wr_keep) | wr_word;
        FEAT_IEN: ien_q <= (ien_q & wr_keep) | wr_word;
        FEAT_POL: pol_q <= (pol_q & wr_keep) | wr_word;
        FEAT_TYP: typ_q <= (typ_q & wr_keep) | wr_word;
        default:  ;
      endcase
    end
  end

  // Per-pin event detection; absent pins never produce events
  for (genvar i = 0; i < PAD_W; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_live
      gpio_pin_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl_pad[i]),
        .edge_mode  (typ_q[i]),
        .active_low (pol_q[i]),
        .evt        (evt_vec[i])
      );
    end else begin : g_absent
      assign evt_vec[i] = 1'b0;
    end
  end

  // Sticky status: a new event outranks a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_vec) | evt_vec) & VALID_MASK;
  end

  always_comb begin
    reg_rdata = '0;
    case (feat)
      FEAT_DIR:  reg_rdata = dir_q[WORD_W*int'(bank) +: WORD_W];
      FEAT_DRV:  reg_rdata = lvl_pad[WORD_W*int'(bank) +: WORD_W];
      FEAT_IEN:  reg_rdata = ien_q[WORD_W*int'(bank) +: WORD_W];
      FEAT_POL:  reg_rdata = pol_q[WORD_W*int'(bank) +: WORD_W];
      FEAT_TYP:  reg_rdata = typ_q[WORD_W*int'(bank) +: WORD_W];
      FEAT_STAT: reg_rdata = stat_q[WORD_W*int'(bank) +: WORD_W];
      default:   reg_rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q[NUM_PINS-1:0];
  assign pin_out = drv_q[NUM_PINS-1:0];
  assign irq_out = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8,
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int PAD_W     = NUM_BANKS * WORD_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr_en,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_out,
  input logic [PAD_W-1:0]    ien_q,
  input logic [PAD_W-1:0]    stat_q,
  input logic [PAD_W-1:0]    clr_vec
);
  function automatic logic [PAD_W-1:0] pin_mask();
    logic [PAD_W-1:0] m;
    for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction
  localparam logic [PAD_W-1:0] VALID_MASK = pin_mask();

  logic [PAD_W-1:0] oe_pad;
  assign oe_pad = PAD_W'(pin_oe);

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_out && stat_q == '0));

  // R3: a write to the first direction word drives the output enables
  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'(OFS_DIR)) |=>
      (oe_pad[WORD_W-1:0] == ($past(reg_wdata) & VALID_MASK[WORD_W-1:0])));

  // R7: a set status bit only falls through a clear
  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0));

  // R9: no enabled pin, no interrupt
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_out);

  // R10: absent pins hold no enable and no status
  a_r10_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | ien_q) & ~VALID_MASK) == '0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .ien_q     (ien_q),
  .stat_q    (stat_q),
  .clr_vec   (clr_vec)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int NP = 40;
  localparam logic [7:0] A_DIR = 8'h00, A_DRV = 8'h08, A_IEN = 8'h18,
                         A_POL = 8'h38, A_TYP = 8'h40, A_STAT = 8'h48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr_en(wr_en),
    .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic clear_cfg();
    for (int b = 0; b < 2; b++) begin
      wr(A_TYP + 8'(b * 4), 0); wr(A_POL + 8'(b * 4), 0); wr(A_IEN + 8'(b * 4), 0);
    end
  endtask

  task automatic sweep_pin(input int p, input int m);
    logic [31:0] d, bw;
    logic [7:0]  ba;
    logic typ, pol;
    typ = m[1]; pol = m[0];
    bw = 32'h1 << (p % 32);
    ba = 8'((p / 32) * 4);
    clear_cfg();
    wr(A_TYP + ba, typ ? bw : 0);
    wr(A_POL + ba, pol ? bw : 0);
    pin_in = '0; pin_in[p] = pol;
    repeat (4) @(posedge clk);
    wr(A_STAT, 32'hFFFF_FFFF); wr(A_STAT + 4, 32'hFFFF_FFFF);
    rd(A_STAT + ba, d); chk("R7", $sformatf("idle clear p%0d m%0d", p, m), d, 0);
    pin_in[p] = ~pol;
    repeat (4) @(posedge clk);
    rd(A_STAT + ba, d);
    chk(typ ? "R6" : "R5", $sformatf("active sets p%0d m%0d", p, m), d, bw);
    rd(A_STAT + (ba ^ 8'h4), d);
    chk("R2", $sformatf("other bank clean p%0d m%0d", p, m), d, 0);
    chk("R9", $sformatf("disabled no irq p%0d m%0d", p, m), irq, 0);
    wr(A_IEN + ba, bw);
    chk("R9", $sformatf("enabled irq p%0d m%0d", p, m), irq, 1);
    wr(A_IEN + ba, 0);
    chk("R9", $sformatf("re-disabled p%0d m%0d", p, m), irq, 0);
    wr(A_STAT + ba, 0);
    rd(A_STAT + ba, d); chk("R7", $sformatf("zero write keeps p%0d m%0d", p, m), d, bw);
    wr(A_STAT + ba, bw);
    rd(A_STAT + ba, d);
    chk(typ ? "R7" : "R5", $sformatf("after clear p%0d m%0d", p, m), d, typ ? 0 : bw);
    pin_in[p] = pol;
    repeat (4) @(posedge clk);
    rd(A_STAT + ba, d);
    chk(typ ? "R6" : "R7", $sformatf("leave active p%0d m%0d", p, m), d, typ ? 0 : bw);
    wr(A_STAT + ba, bw);
    rd(A_STAT + ba, d); chk("R7", $sformatf("final clear p%0d m%0d", p, m), d, 0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    foreach (d[i]) ;
    for (int b = 0; b < 2; b++) begin
      rd(A_DIR + 8'(b * 4), d);  chk("R1", "dir", d, 0);
      rd(A_DRV + 8'(b * 4), d);  chk("R1", "drv", d, 0);
      rd(A_IEN + 8'(b * 4), d);  chk("R1", "ien", d, 0);
      rd(A_POL + 8'(b * 4), d);  chk("R1", "pol", d, 0);
      rd(A_TYP + 8'(b * 4), d);  chk("R1", "typ", d, 0);
      rd(A_STAT + 8'(b * 4), d); chk("R1", "stat", d, 0);
    end
    chk("R1", "pin_oe", pin_oe, 0);
    chk("R1", "pin_out", pin_out, 0);
    chk("R1", "irq", irq, 0);

    // R2 / R10: readback and partial bank
    wr(A_DIR, 32'hDEAD_BEEF); wr(A_DIR + 4, 32'hFFFF_FFFF);
    rd(A_DIR, d); chk("R2", "dir bank0", d, 32'hDEAD_BEEF);
    rd(A_DIR + 4, d); chk("R10", "dir bank1", d, 32'h0000_00FF);
    wr(A_TYP, 32'h0F0F_5555); wr(A_TYP + 4, 32'hFFFF_FF3C);
    rd(A_TYP, d); chk("R2", "typ bank0", d, 32'h0F0F_5555);
    rd(A_TYP + 4, d); chk("R10", "typ bank1", d, 32'h0000_003C);
    wr(A_POL, 32'h1234_5678); wr(A_POL + 4, 32'hAAAA_AAAA);
    rd(A_POL, d); chk("R2", "pol bank0", d, 32'h1234_5678);
    rd(A_POL + 4, d); chk("R10", "pol bank1", d, 32'h0000_00AA);
    wr(A_IEN + 4, 32'hFFFF_FF00);
    rd(A_IEN + 4, d); chk("R10", "ien bank1 absent", d, 0);
    rd(8'h10, d); chk("R2", "unmapped", d, 0);
    rd(8'h50, d); chk("R2", "unmapped high", d, 0);

    // R3: direction and drive
    wr(A_DIR, 32'hF0F0_0F0F); wr(A_DIR + 4, 32'h3C);
    wr(A_DRV, 32'h1357_9BDF); wr(A_DRV + 4, 32'hFF);
    chk("R3", "pin_oe", pin_oe, 40'h3C_F0F0_0F0F);
    chk("R3", "pin_out", pin_out, 40'hFF_1357_9BDF);

    // R4: drive word reads synchronised pin level
    clear_cfg();
    @(negedge clk) pin_in = 40'hA5_1234_5678;
    @(posedge clk);
    rd(A_DRV, d); chk("R4", "one edge old", d, 0);
    @(posedge clk);
    rd(A_DRV, d); chk("R4", "two edges new", d, 32'h1234_5678);
    rd(A_DRV + 4, d); chk("R4", "bank1 level", d, 32'h0000_00A5);
    wr(A_DIR, 0); wr(A_DIR + 4, 0);

    // R5 R6 R7 R9 sweep
    foreach (d[i]) ;
    for (int k = 0; k < 5; k++) begin
      int p;
      p = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 31 : (k == 3) ? 32 : 39;
      for (int m = 0; m < 4; m++) sweep_pin(p, m);
    end

    // R8: rising edge on pin 3 coincides with a clear
    clear_cfg();
    wr(A_TYP, 32'h8);
    pin_in = '0;
    repeat (4) @(posedge clk);
    wr(A_STAT, 32'hFFFF_FFFF); wr(A_STAT + 4, 32'hFFFF_FFFF);
    @(negedge clk) pin_in[3] = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_STAT, d); chk("R8", "first edge", d, 32'h8);
    @(negedge clk) pin_in[3] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) pin_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); chk("R8", "event beats clear", d, 32'h8);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); chk("R8", "later clear", d, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule